// File: doc/BRIEF.md
# Oversampled Echo Sample Picker

The block accepts a stream of 8-bit echo samples that arrive at four times the pixel density along a scan vector. For each pixel line it keeps the one sample that falls closest to that line and marks the others for discard. A downstream writer stores only the kept samples, so the data volume drops by about a factor of four. The writer also needs the vector number and a length code for each vector's header, and the block supplies both.

The per-vector geometry is stored once for a quarter sweep. The sweep is symmetric, so 512 vector numbers fold onto 128 table rows, and the second half of each 256-vector pass reads the rows in reverse. Each row holds three values. The first is a signed 16.32 fixed-point starting distance. The second is an unsigned 32-bit fractional step between samples. The third is an 8-bit code equal to the vector's pixel count minus 300. When a vector starts, a 48-bit running distance is loaded with the starting distance, and it grows by one step for each sample. A sample is kept when its running distance lies within half a step of an integer pixel line. The work is split into four registered stages: address fold, table read, distance accumulation and window test.

Top module: `echo_sample_picker`

## Requirements
- R1: The 9-bit vector number v folds to table row v[6:0] when v[7] is 0, and to row 127 − v[6:0] when v[7] is 1. So vectors 0–127 and 256–383 read rows 0 to 127 in order, and vectors 128–255 and 384–511 read rows 127 down to 0.
- R2: A table write (`tbl_we` high at a clock edge) stores `tbl_iv`, `tbl_delta` and `tbl_len` at row `tbl_addr`. Every vector that later folds onto that row uses the new values.
- R3: Every input sample cycle reappears at the outputs exactly four clock edges later. `out_stb` equals the delayed `smp_stb`, and `out_data` equals the delayed `smp_data` unchanged.
- R4: A vector starts on the first cycle in which `vec_valid` is high after a cycle in which it was low. The k-th strobed sample of that vector (k = 0 first, counting only samples with `vec_valid` high) is tested at distance IV + k·Δ modulo 2^48, where IV and Δ come from the vector's row.
- R5: Let h = Δ >> 1 (logical shift). When the integer part (bits 47:32) of the tested distance is non-negative, the sample is kept if its fraction is at least 0xFFFFFFFF − h, or if the fraction is below h.
- R6: When the integer part is 0xFFFF (value −1), the sample is kept if its fraction is at least (2^32 − h) mod 2^32. For any other negative integer part, the sample is discarded.
- R7: `out_good_n` is active low. 0 means keep. It is 1 in every cycle in which `out_stb` is 0.
- R8: A sample strobed while `vec_valid` is low comes out with `out_good_n` = 1.
- R9: `out_start` pulses for one cycle, aligned with the delayed vector-start cycle. In that same cycle `out_vec` takes the vector number and `out_len` takes the row's length code. Both hold until the next start.
- R10: While `rst_n` is low, `out_stb`, `out_start`, `out_data`, `out_vec` and `out_len` are 0, and `out_good_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table row write enable |
| tbl_addr | input | 7 | Table row to write |
| tbl_iv | input | 48 | Starting distance, signed 16.32 |
| tbl_delta | input | 32 | Step between samples, unsigned fraction |
| tbl_len | input | 8 | Pixel count minus 300 |
| vec_num | input | 9 | Current vector number, stable while valid |
| vec_valid | input | 1 | High while a vector's samples flow |
| smp_stb | input | 1 | Sample present this cycle |
| smp_data | input | 8 | Echo sample |
| out_stb | output | 1 | Delayed sample strobe |
| out_data | output | 8 | Delayed echo sample |
| out_start | output | 1 | Delayed vector-start pulse |
| out_good_n | output | 1 | 0 = keep this sample |
| out_vec | output | 9 | Vector number of current vector |
| out_len | output | 8 | Length code of current vector |

## Verification
Vectors are run at all four fold boundaries (0, 127, 128, 255, 256, 383, 384, 511) plus interior and mirrored pairs. Because every table row carries a distinct length code, a wrong fold shows up in the header. Strobes come either on every cycle or in a pseudo-random gapped pattern: the first shows whether the start cycle also counts as sample zero, and the second separates accumulation per sample from accumulation per clock. Starting distances reach below −1, and one row has a zero step, which separates the non-negative window, the −1 window and the plain-discard branch. Strobes with `vec_valid` low and a table row rewritten mid-run cover the gating and the write path.

// File: rtl/echo_sample_picker.sv
module echo_sample_picker #(
  parameter int ROW_W  = 7,
  parameter int VEC_W  = 9,
  parameter int DW     = 8,
  parameter int IW     = 16,
  parameter int FW     = 32,
  parameter int LW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tbl_we,
  input  logic [ROW_W-1:0]     tbl_addr,
  input  logic [IW+FW-1:0]     tbl_iv,
  input  logic [FW-1:0]        tbl_delta,
  input  logic [LW-1:0]        tbl_len,
  input  logic [VEC_W-1:0]     vec_num,
  input  logic                 vec_valid,
  input  logic                 smp_stb,
  input  logic [DW-1:0]        smp_data,
  output logic                 out_stb,
  output logic [DW-1:0]        out_data,
  output logic                 out_start,
  output logic                 out_good_n,
  output logic [VEC_W-1:0]     out_vec,
  output logic [LW-1:0]        out_len
);
  localparam int AW   = IW + FW;
  localparam int ROWS = 1 << ROW_W;

  logic [AW-1:0] iv_mem [ROWS];
  logic [FW-1:0] dl_mem [ROWS];
  logic [LW-1:0] ln_mem [ROWS];

  always_ff @(posedge clk)
    if (tbl_we) begin
      iv_mem[tbl_addr] <= tbl_iv;
      dl_mem[tbl_addr] <= tbl_delta;
      ln_mem[tbl_addr] <= tbl_len;
    end

  // stage 1: fold vector number onto a table row
  logic             s1_stb, s1_valid, s1_start;
  logic [DW-1:0]    s1_data;
  logic [VEC_W-1:0] s1_vec;
  logic [ROW_W-1:0] s1_row;

  always_ff @(posedge clk)
    if (!rst_n) begin
      s1_stb <= 1'b0; s1_valid <= 1'b0; s1_start <= 1'b0;
      s1_data <= '0; s1_vec <= '0; s1_row <= '0;
    end else begin
      s1_stb   <= smp_stb;
      s1_valid <= vec_valid;
      s1_start <= vec_valid & ~s1_valid;
      s1_data  <= smp_data;
      s1_vec   <= vec_num;
      s1_row   <= vec_num[ROW_W-1:0] ^ {ROW_W{vec_num[ROW_W]}};
    end

  // stage 2: table read
  logic             s2_stb, s2_valid, s2_start;
  logic [DW-1:0]    s2_data;
  logic [VEC_W-1:0] s2_vec;
  logic [AW-1:0]    s2_iv;
  logic [FW-1:0]    s2_delta;
  logic [LW-1:0]    s2_len;

  always_ff @(posedge clk) begin
    s2_iv    <= iv_mem[s1_row];
    s2_delta <= dl_mem[s1_row];
    s2_len   <= ln_mem[s1_row];
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      s2_stb <= 1'b0; s2_valid <= 1'b0; s2_start <= 1'b0;
      s2_data <= '0; s2_vec <= '0;
    end else begin
      s2_stb   <= s1_stb;
      s2_valid <= s1_valid;
      s2_start <= s1_start;
      s2_data  <= s1_data;
      s2_vec   <= s1_vec;
    end

  // stage 3: running distance
  logic             s3_stb, s3_valid, s3_start;
  logic [DW-1:0]    s3_data;
  logic [VEC_W-1:0] s3_vec;
  logic [LW-1:0]    s3_len;
  logic [FW-1:0]    s3_delta;
  logic [AW-1:0]    s3_cnt, run;
  logic [AW-1:0]    base;

  assign base = s2_start ? s2_iv : run;

  always_ff @(posedge clk)
    if (!rst_n) begin
      s3_stb <= 1'b0; s3_valid <= 1'b0; s3_start <= 1'b0;
      s3_data <= '0; s3_vec <= '0; s3_len <= '0; s3_delta <= '0;
      s3_cnt <= '0; run <= '0;
    end else begin
      s3_stb   <= s2_stb;
      s3_valid <= s2_valid;
      s3_start <= s2_start;
      s3_data  <= s2_data;
      s3_vec   <= s2_vec;
      s3_len   <= s2_len;
      s3_delta <= s2_delta;
      if (s2_start) run <= s2_iv;
      if (s2_stb && s2_valid) begin
        s3_cnt <= base;
        run    <= base + {{IW{1'b0}}, s2_delta};
      end
    end

  // stage 4: window test around the nearest pixel line
  logic [IW-1:0] ipart;
  logic [FW-1:0] frac, half, neg_half;
  logic          keep;

  assign ipart    = s3_cnt[AW-1:FW];
  assign frac     = s3_cnt[FW-1:0];
  assign half     = s3_delta >> 1;
  assign neg_half = ~half + {{(FW-1){1'b0}}, 1'b1};

  always_comb begin
    if (!ipart[IW-1])        keep = (frac >= ~half) || (frac < half);
    else if (&ipart)         keep = (frac >= neg_half);
    else                     keep = 1'b0;
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      out_stb <= 1'b0; out_start <= 1'b0; out_good_n <= 1'b1;
      out_data <= '0; out_vec <= '0; out_len <= '0;
    end else begin
      out_stb    <= s3_stb;
      out_data   <= s3_data;
      out_start  <= s3_start;
      out_good_n <= ~(s3_stb && s3_valid && keep);
      if (s3_start) begin
        out_vec <= s3_vec;
        out_len <= s3_len;
      end
    end

  // assertions
  logic [2:0] warm;
  always_ff @(posedge clk)
    if (!rst_n) warm <= '0;
    else if (warm != 3'd4) warm <= warm + 3'd1;

  assert_keep_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_stb |-> out_good_n);

  assert_four_cycle_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3'd4) |-> (out_stb == $past(smp_stb, 4)) && (out_data == $past(smp_data, 4)));

  assert_idle_sample_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3'd4) && $past(smp_stb, 4) && !$past(vec_valid, 4) |-> out_good_n);

  assert_header_moves_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_vec != $past(out_vec)) || (out_len != $past(out_len))) |-> out_start);

  assert_fold_row_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vec[ROW_W] ? ((s1_row + s1_vec[ROW_W-1:0]) == ROW_W'(ROWS - 1))
                  : (s1_row == s1_vec[ROW_W-1:0]));
endmodule

// File: tb/tb_echo_sample_picker.sv
`timescale 1ns/1ps
module tb_echo_sample_picker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        tbl_we = 0;
  logic [6:0]  tbl_addr = 0;
  logic [47:0] tbl_iv = 0;
  logic [31:0] tbl_delta = 0;
  logic [7:0]  tbl_len = 0;
  logic [8:0]  vec_num = 0;
  logic        vec_valid = 0, smp_stb = 0;
  logic [7:0]  smp_data = 0;
  logic        out_stb, out_start, out_good_n;
  logic [7:0]  out_data, out_len;
  logic [8:0]  out_vec;

  echo_sample_picker dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_iv(tbl_iv),
    .tbl_delta(tbl_delta), .tbl_len(tbl_len), .vec_num(vec_num), .vec_valid(vec_valid),
    .smp_stb(smp_stb), .smp_data(smp_data), .out_stb(out_stb), .out_data(out_data),
    .out_start(out_start), .out_good_n(out_good_n), .out_vec(out_vec), .out_len(out_len));

  int total = 0, bad = 0, n = 0;
  bit [47:0] t_iv [128];
  bit [31:0] t_dl [128];
  bit [7:0]  t_ln [128];
  bit        m_prev = 0;
  bit [47:0] m_run = 0;
  bit [8:0]  h_vec = 0;
  bit [7:0]  h_len = 0;
  bit [15:0] rng = 16'hACE1;
  string     htag = "R1 R9";

  bit        e_stb [8], e_start [8], e_gn [8];
  bit [7:0]  e_data [8], e_len [8];
  bit [8:0]  e_vec [8];
  string     e_tag [8], e_htag [8];

  function automatic int fold(int v);
    int a = v % 128;
    if (((v / 128) % 2) == 1) a = 127 - a;
    return a;
  endfunction

  function automatic bit keep_ref(bit [47:0] c, bit [31:0] d);
    bit [31:0] h = d >> 1;
    bit [31:0] f = c[31:0];
    if (c[47] == 1'b0) return (f >= 32'hFFFF_FFFF - h) || (f < h);
    if (c[47:32] == 16'hFFFF) return f >= (32'h0 - h);
    return 1'b0;
  endfunction

  function automatic bit [15:0] nxt(bit [15:0] r);
    return r[0] ? ((r >> 1) ^ 16'hB400) : (r >> 1);
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, n);
    end
  endtask

  task automatic tick(int v, bit val, bit stb, bit [7:0] d,
                      bit we = 0, int wa = 0, bit [47:0] wi = 0, bit [31:0] wd = 0, bit [7:0] wl = 0);
    int s, a;
    bit st;
    bit [47:0] cnt;
    @(negedge clk);
    if (n >= 4) begin
      s = (n - 4) % 8;
      chk(out_stb == e_stb[s], "R3", "strobe", out_stb, e_stb[s]);
      chk(out_data == e_data[s], "R3", "data", out_data, e_data[s]);
      chk(out_good_n == e_gn[s], e_tag[s], "good_n", out_good_n, e_gn[s]);
      chk(out_start == e_start[s], "R9", "start", out_start, e_start[s]);
      chk(out_vec == e_vec[s], e_htag[s], "vec", out_vec, e_vec[s]);
      chk(out_len == e_len[s], e_htag[s], "len", out_len, e_len[s]);
    end
    s = n % 8;
    st = val && !m_prev;
    m_prev = val;
    a = fold(v);
    if (st) begin h_vec = 9'(v); h_len = t_ln[a]; m_run = t_iv[a]; end
    e_gn[s] = 1'b1;
    e_tag[s] = "R7";
    if (stb) begin
      if (val) begin
        cnt = m_run;
        m_run = cnt + {16'h0, t_dl[a]};
        e_gn[s] = !keep_ref(cnt, t_dl[a]);
        e_tag[s] = cnt[47] ? "R4 R6 R7" : "R4 R5 R7";
      end else e_tag[s] = "R8";
    end
    e_stb[s] = stb; e_data[s] = d; e_start[s] = st;
    e_vec[s] = h_vec; e_len[s] = h_len; e_htag[s] = htag;
    if (we) begin t_iv[wa] = wi; t_dl[wa] = wd; t_ln[wa] = wl; end
    vec_num = 9'(v); vec_valid = val; smp_stb = stb; smp_data = d;
    tbl_we = we; tbl_addr = 7'(wa); tbl_iv = wi; tbl_delta = wd; tbl_len = wl;
    n++;
  endtask

  task automatic run_vec(int v, int ns, bit gappy);
    int got = 0;
    tick(v, 0, 0, 0);
    while (got < ns) begin
      bit s;
      rng = nxt(rng);
      s = gappy ? rng[3] : 1'b1;
      tick(v, 1, s, rng[11:4]);
      if (s) got++;
    end
    tick(v, 0, 1, 8'h3C);
    tick(v, 0, 0, 0);
    tick(v, 0, 1, 8'hC3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_stb == 0 && out_start == 0 && out_data == 0, "R10", "reset strobes/data",
        {out_stb, out_start, out_data}, 0);
    chk(out_good_n == 1, "R10", "reset good_n", out_good_n, 1);
    chk(out_vec == 0 && out_len == 0, "R10", "reset header", {out_vec, out_len}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 128; i++) begin
      bit [47:0] iv = 48'h0 - 48'(i) * 48'h0000_1234_5678;
      bit [31:0] dl = 32'h3000_0000 + 32'(i) * 32'h0021_4365;
      if (i == 64) begin iv = 48'hFFFF_8000_0000; dl = 32'h0; end
      tick(0, 0, 0, 0, 1, i, iv, dl, 8'(i) ^ 8'h5A);
    end
    foreach (t_ln[k]) ;
    run_vec(0, 2048, 0);
    run_vec(127, 300, 1);
    run_vec(128, 300, 0);
    run_vec(255, 300, 1);
    run_vec(256, 300, 1);
    run_vec(383, 300, 0);
    run_vec(384, 300, 1);
    run_vec(511, 300, 0);
    run_vec(64, 40, 1);
    run_vec(200, 400, 1);
    run_vec(450, 400, 0);
    htag = "R2 R1 R9";
    tick(0, 0, 0, 0, 1, 5, 48'hFFFE_C000_0000, 32'h4000_0000, 8'hA7);
    run_vec(5, 300, 1);
    run_vec(250, 300, 0);
    repeat (6) tick(0, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule